// File: doc/BRIEF.md
# BCD Calendar Clock with Rate Trim

This block keeps wall-clock time and calendar date as packed BCD counters: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A prescaler divides the system clock down to a one-second tick. Once a minute, the length of the last second is stretched or shortened by a signed trim value, so a slow or fast reference can be corrected in fine steps. Speeding up and slowing down use different step sizes.

Software reaches the block through a single-clock register port with eight byte-wide locations: a control byte and the seven time fields. Setting the freeze bit holds the time fields still so that a multi-byte read is coherent. A second that falls due during the freeze is kept and applied as soon as the freeze is lifted. Setting the load bit stops counting and opens the time fields to writes. Clearing it commits the new time and restarts the second from zero. Out-of-range BCD values written under the load bit are forced into the field's legal range.

A small state machine sequences these modes. The states are ST_RUN (counting), ST_FROZEN (freeze bit set, no second owed), ST_PENDING (freeze bit set, one second owed) and ST_LOAD (load bit set). The transitions are:
- any state to ST_LOAD while the load bit is set.
- ST_RUN, ST_FROZEN or ST_LOAD to ST_FROZEN when the freeze bit is set and no tick occurs.
- ST_RUN, ST_FROZEN or ST_LOAD to ST_PENDING on a tick under freeze.
- ST_PENDING holds while freeze stays.
- every state to ST_RUN once both bits are clear, with the owed second applied on the way out of ST_PENDING.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, reads return seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00 and control 00.
- R2: With zero trim, seconds advance once every DIV_CYCLES clocks in BCD. Seconds and minutes wrap 59 to 00 and carry. Hours wrap 23 to 00 and carry into the date.
- R3: Day of week (address 4) counts 1 to 7 and wraps from 7 to 1 at each midnight.
- R4: At midnight the date wraps to 01 after day 30 for months 04, 06, 09 and 11, and after day 31 for the other months. For month 02 it wraps after day 29 when the binary value of the year is divisible by 4 (00 included), otherwise after day 28. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R5: Address 0 is the control byte. Bits 4:0 hold the trim magnitude, bit 5 the trim sign (1 = negative), bit 6 the freeze bit and bit 7 the load bit. It is always writable and reads back as written. The time fields sit at 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month and 7 year.
- R6: While the freeze bit is 1 and the load bit is 0, no time field changes. A tick that falls due in that time is kept, and the seconds advance in the first cycle after the freeze bit reads 0.
- R7: While the load bit is 1, counting stops, the prescaler is held at zero and writes to addresses 1 to 7 load the fields. After the bit clears, the first increment comes a full DIV_CYCLES clocks later.
- R8: Writes to addresses 1 to 7 while the load bit is 0 leave every time field unchanged.
- R9: A value written under the load bit that has a BCD digit above 9, or that exceeds the field maximum, is stored as the maximum (59, 59, 23, 7, 31, 12, 99). A value below the field minimum (1 for day of week, date and month) is stored as the minimum.
- R10: The second during which the seconds read 59 lasts DIV_CYCLES − magnitude×POS_STEP clocks when the sign is 0, and DIV_CYCLES + magnitude×NEG_STEP clocks when the sign is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 3 | Register address (0 control, 1 to 7 time fields) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
The assertions assume a few things about the inputs:
- Software keeps the freeze bit set for less than one second, because only one owed tick can be kept.
- DIV_CYCLES is larger than 31×POS_STEP, so that a fully positive trim still leaves a second of at least one clock.
- Time fields are only written under the load bit or with the intent that the write be dropped.

The stimulus holds each freeze for about a hundred clocks at DIV_CYCLES = 100, so exactly one tick falls inside it. It sets the trim only to values within ±31. It enters every calendar corner (month ends, leap and common February, century wrap) through the load path, so the counters never hold an illegal value that the range checks would flag.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_FROZEN,
        ST_PENDING,
        ST_LOAD
    } rtc_state_e;

    localparam int FREEZE_BIT = 6;
    localparam int LOAD_BIT   = 7;
    localparam int SIGN_BIT   = 5;

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [7:0] bcd_step(input logic [7:0] b);
        return (b[3:0] == 4'd9) ? {b[7:4] + 4'd1, 4'd0} : b + 8'd1;
    endfunction

    function automatic logic [7:0] bcd_clamp(input logic [7:0] d,
                                             input logic [6:0] lo,
                                             input logic [6:0] hi);
        logic [6:0] v;
        if (d[7:4] > 4'd9 || d[3:0] > 4'd9) return bin_to_bcd(hi);
        v = bcd_to_bin(d);
        if (v > hi) return bin_to_bcd(hi);
        if (v < lo) return bin_to_bcd(lo);
        return d;
    endfunction

    function automatic logic [6:0] days_in_month(input logic [7:0] mon,
                                                 input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = bcd_to_bin(yr);
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'd0) ? 7'd29 : 7'd28;
            8'h04, 8'h06, 8'h09, 8'h11: return 7'd30;
            default:                    return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_CYCLES = 100,
    parameter int POS_STEP   = 2,
    parameter int NEG_STEP   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       last_sec,
    input  logic [4:0] trim_mag,
    input  logic       trim_neg,
    output logic       tick
);
    localparam int CNT_W = $clog2(DIV_CYCLES + 31 * NEG_STEP + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // trim only reshapes the final second of each minute
    always_comb begin
        if (!last_sec)
            limit = CNT_W'(DIV_CYCLES);
        else if (trim_neg)
            limit = CNT_W'(DIV_CYCLES) + CNT_W'(trim_mag) * CNT_W'(NEG_STEP);
        else
            limit = CNT_W'(DIV_CYCLES) - CNT_W'(trim_mag) * CNT_W'(POS_STEP);
    end

    assign tick = !clear && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/rtc_ctrl_fsm.sv
module rtc_ctrl_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freeze,
    input  logic       load,
    input  logic       tick,
    output logic       advance,
    output logic       presc_clear,
    output rtc_state_e state_o
);
    rtc_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN, ST_FROZEN, ST_LOAD: begin
                if (load)        state_n = ST_LOAD;
                else if (freeze) state_n = tick ? ST_PENDING : ST_FROZEN;
                else             state_n = ST_RUN;
            end
            ST_PENDING: begin
                if (load)        state_n = ST_LOAD;
                else if (freeze) state_n = ST_PENDING;
                else             state_n = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_n;
    end

    always_comb begin
        presc_clear = load;
        advance     = !load && !freeze && (tick || state_q == ST_PENDING);
    end

    assign state_o = state_q;
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    input  logic       ld_en,
    input  logic [2:0] ld_addr,
    input  logic [7:0] ld_data,
    output logic [7:0] sec,
    output logic [7:0] min,
    output logic [7:0] hour,
    output logic [7:0] dow,
    output logic [7:0] date,
    output logic [7:0] month,
    output logic [7:0] year
);
    logic [7:0] sec_n, min_n, hour_n, dow_n, date_n, month_n, year_n;
    logic       sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap;

    always_comb begin
        sec_wrap   = (sec == 8'h59);
        min_wrap   = sec_wrap && (min == 8'h59);
        hour_wrap  = min_wrap && (hour == 8'h23);
        date_wrap  = hour_wrap && (bcd_to_bin(date) >= days_in_month(month, year));
        month_wrap = date_wrap && (month == 8'h12);

        sec_n = sec; min_n = min; hour_n = hour; dow_n = dow;
        date_n = date; month_n = month; year_n = year;

        if (advance) begin
            sec_n = sec_wrap ? 8'h00 : bcd_step(sec);
            if (sec_wrap)   min_n   = (min == 8'h59) ? 8'h00 : bcd_step(min);
            if (min_wrap)   hour_n  = (hour == 8'h23) ? 8'h00 : bcd_step(hour);
            if (hour_wrap)  dow_n   = (dow == 8'h07) ? 8'h01 : dow + 8'd1;
            if (hour_wrap)  date_n  = date_wrap ? 8'h01 : bcd_step(date);
            if (date_wrap)  month_n = month_wrap ? 8'h01 : bcd_step(month);
            if (month_wrap) year_n  = (year == 8'h99) ? 8'h00 : bcd_step(year);
        end else if (ld_en) begin
            case (ld_addr)
                3'd1:    sec_n   = bcd_clamp(ld_data, 7'd0, 7'd59);
                3'd2:    min_n   = bcd_clamp(ld_data, 7'd0, 7'd59);
                3'd3:    hour_n  = bcd_clamp(ld_data, 7'd0, 7'd23);
                3'd4:    dow_n   = bcd_clamp(ld_data, 7'd1, 7'd7);
                3'd5:    date_n  = bcd_clamp(ld_data, 7'd1, 7'd31);
                3'd6:    month_n = bcd_clamp(ld_data, 7'd1, 7'd12);
                3'd7:    year_n  = bcd_clamp(ld_data, 7'd0, 7'd99);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec <= 8'h00; min <= 8'h00; hour <= 8'h00; dow <= 8'h01;
            date <= 8'h01; month <= 8'h01; year <= 8'h00;
        end else begin
            sec <= sec_n; min <= min_n; hour <= hour_n; dow <= dow_n;
            date <= date_n; month <= month_n; year <= year_n;
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int DIV_CYCLES = 100,
    parameter int POS_STEP   = 2,
    parameter int NEG_STEP   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    logic [7:0] ctrl_q;
    logic       tick, advance, presc_clear, ld_en;
    rtc_state_e fsm_state;
    logic [7:0] t_sec, t_min, t_hour, t_dow, t_date, t_month, t_year;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ctrl_q <= 8'h00;
        else if (reg_we && reg_addr == 3'd0) ctrl_q <= reg_wdata;
    end

    assign ld_en = reg_we && (reg_addr != 3'd0) && ctrl_q[LOAD_BIT];

    rtc_prescaler #(
        .DIV_CYCLES(DIV_CYCLES),
        .POS_STEP  (POS_STEP),
        .NEG_STEP  (NEG_STEP)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (presc_clear),
        .last_sec(t_sec == 8'h59),
        .trim_mag(ctrl_q[4:0]),
        .trim_neg(ctrl_q[SIGN_BIT]),
        .tick    (tick)
    );

    rtc_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .freeze     (ctrl_q[FREEZE_BIT]),
        .load       (ctrl_q[LOAD_BIT]),
        .tick       (tick),
        .advance    (advance),
        .presc_clear(presc_clear),
        .state_o    (fsm_state)
    );

    rtc_time_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(advance),
        .ld_en  (ld_en),
        .ld_addr(reg_addr),
        .ld_data(reg_wdata),
        .sec    (t_sec),
        .min    (t_min),
        .hour   (t_hour),
        .dow    (t_dow),
        .date   (t_date),
        .month  (t_month),
        .year   (t_year)
    );

    always_comb begin
        case (reg_addr)
            3'd0:    reg_rdata = ctrl_q;
            3'd1:    reg_rdata = t_sec;
            3'd2:    reg_rdata = t_min;
            3'd3:    reg_rdata = t_hour;
            3'd4:    reg_rdata = t_dow;
            3'd5:    reg_rdata = t_date;
            3'd6:    reg_rdata = t_month;
            default: reg_rdata = t_year;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       freeze,
    input logic       load,
    input logic       pending,
    input logic       tick,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] hour,
    input logic [7:0] dow,
    input logic [7:0] date,
    input logic [7:0] month
);
    AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sec[3:0] <= 4'd9 && sec <= 8'h59 && min[3:0] <= 4'd9 && min <= 8'h59); // R2
    AST_HOUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        hour[3:0] <= 4'd9 && hour <= 8'h23); // R2
    AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dow >= 8'h01 && dow <= 8'h07); // R3
    AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        month >= 8'h01 && month <= 8'h12 && date >= 8'h01 && date <= 8'h31); // R4
    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !load) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(date))); // R6
    AST_PENDING_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !freeze && !load) |=> !$stable(sec)); // R6
    AST_LOAD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !tick); // R7
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick && !pending) |=> ($stable(sec) && $stable(min) && $stable(dow))); // R8
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (ctrl_q[6]),
    .load   (ctrl_q[7]),
    .pending(fsm_state == rtc_pkg::ST_PENDING),
    .tick   (tick),
    .sec    (t_sec),
    .min    (t_min),
    .hour   (t_hour),
    .dow    (t_dow),
    .date   (t_date),
    .month  (t_month)
);

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
    localparam int DIV = 100;
    localparam int PST = 2;
    localparam int NST = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int n_total = 0, n_bad = 0;
    int c_total = 0, c_bad = 0;

    always #5 clk = ~clk;

    rtc_calendar #(.DIV_CYCLES(DIV), .POS_STEP(PST), .NEG_STEP(NST)) u_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // ---------------- behavioural reference ----------------
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cnt;
    bit m_pend;
    logic [7:0] m_ctrl;

    function automatic int mdays(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int fit(logic [7:0] d, int lo, int hi);
        int v;
        if (d[7:4] > 4'd9 || d[3:0] > 4'd9) return hi;
        v = int'(d[7:4]) * 10 + int'(d[3:0]);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic logic [7:0] model_read(logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return to_bcd(m_sec);
            3'd2: return to_bcd(m_min);
            3'd3: return to_bcd(m_hr);
            3'd4: return to_bcd(m_dow);
            3'd5: return to_bcd(m_date);
            3'd6: return to_bcd(m_mon);
            default: return to_bcd(m_yr);
        endcase
    endfunction

    task automatic model_second();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    if (m_date >= mdays(m_mon, m_yr)) begin
                        m_date = 1;
                        if (m_mon == 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
                        else m_mon++;
                    end else m_date++;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
            m_ctrl = 8'h00; m_cnt = 0; m_pend = 1'b0;
        end else begin
            bit wr, rd, tk, adv;
            int lim;
            wr = m_ctrl[7]; rd = m_ctrl[6];
            if (m_sec != 59) lim = DIV;
            else if (m_ctrl[5]) lim = DIV + int'(m_ctrl[4:0]) * NST;
            else lim = DIV - int'(m_ctrl[4:0]) * PST;
            tk  = !wr && (m_cnt == lim - 1);
            adv = !wr && !rd && (tk || m_pend);
            m_pend = !wr && rd && (m_pend || tk);
            m_cnt = (wr || tk) ? 0 : m_cnt + 1;
            if (adv) model_second();
            if (reg_we) begin
                if (reg_addr == 3'd0) m_ctrl = reg_wdata;
                else if (wr) begin
                    case (reg_addr)
                        3'd1: m_sec  = fit(reg_wdata, 0, 59);
                        3'd2: m_min  = fit(reg_wdata, 0, 59);
                        3'd3: m_hr   = fit(reg_wdata, 0, 23);
                        3'd4: m_dow  = fit(reg_wdata, 1, 7);
                        3'd5: m_date = fit(reg_wdata, 1, 31);
                        3'd6: m_mon  = fit(reg_wdata, 1, 12);
                        default: m_yr = fit(reg_wdata, 0, 99);
                    endcase
                end
            end
        end
    end

    // compare the visible register against the reference on every clock
    always begin
        @(posedge clk);
        #3;
        if (rst_n) begin
            c_total++;
            if (reg_rdata !== model_read(reg_addr)) begin
                c_bad++;
                $display("FAIL R2 reference compare addr=%0d actual=%h expected=%h",
                         reg_addr, reg_rdata, model_read(reg_addr));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_total++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dw,
                            logic [7:0] dt, logic [7:0] mo, logic [7:0] y, logic [7:0] trim);
        wr_reg(3'd0, 8'h80 | trim);
        wr_reg(3'd1, s);  wr_reg(3'd2, mi); wr_reg(3'd3, h);
        wr_reg(3'd4, dw); wr_reg(3'd5, dt); wr_reg(3'd6, mo); wr_reg(3'd7, y);
        wr_reg(3'd0, trim);
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic last_second_len(output int n);
        logic [7:0] v;
        int guard = 0;
        n = 0;
        do begin
            rd_reg(3'd1, v);
            if (v == 8'h59) n++;
            guard++;
        end while (v != 8'h00 && guard < 2000);
    endtask

    initial begin
        logic [7:0] v;
        int len;
        wait_cycles(4);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd_reg(3'd0, v); check("R1 ctrl", v, 8'h00);
        rd_reg(3'd1, v); check("R1 sec", v, 8'h00);
        rd_reg(3'd3, v); check("R1 hour", v, 8'h00);
        rd_reg(3'd4, v); check("R1 dow", v, 8'h01);
        rd_reg(3'd5, v); check("R1 date", v, 8'h01);
        rd_reg(3'd6, v); check("R1 month", v, 8'h01);
        rd_reg(3'd7, v); check("R1 year", v, 8'h00);

        // R2 plain counting
        wait_cycles(340);
        rd_reg(3'd1, v); check("R2 seconds after 3.4 s", v, 8'h03);

        // R8 writes ignored without the load bit
        wr_reg(3'd1, 8'h45);
        rd_reg(3'd1, v); check("R8 sec write dropped", v, 8'h03);
        wr_reg(3'd7, 8'h55);
        rd_reg(3'd7, v); check("R8 year write dropped", v, 8'h00);

        // R7 restart timing and R2/R3/R4 month end
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23, 8'h00);
        wait_cycles(94);
        rd_reg(3'd1, v); check("R7 no tick before a full second", v, 8'h58);
        wait_cycles(10);
        rd_reg(3'd1, v); check("R7 first tick one second after commit", v, 8'h59);
        wait_cycles(100);
        rd_reg(3'd3, v); check("R2 hour wraps", v, 8'h00);
        rd_reg(3'd2, v); check("R2 minute wraps", v, 8'h00);
        rd_reg(3'd4, v); check("R3 dow 7 to 1", v, 8'h01);
        rd_reg(3'd5, v); check("R4 common Feb 28 ends", v, 8'h01);
        rd_reg(3'd6, v); check("R4 month to 03", v, 8'h03);

        // R4 leap and month lengths
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h00);
        wait_cycles(150);
        rd_reg(3'd5, v); check("R4 leap Feb 29 exists", v, 8'h29);
        rd_reg(3'd4, v); check("R3 dow 3 to 4", v, 8'h04);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24, 8'h00);
        wait_cycles(150);
        rd_reg(3'd6, v); check("R4 leap Feb 29 ends", v, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00, 8'h00);
        wait_cycles(150);
        rd_reg(3'd5, v); check("R4 year 00 is leap", v, 8'h29);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10, 8'h00);
        wait_cycles(150);
        rd_reg(3'd6, v); check("R4 April has 30 days", v, 8'h05);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h10, 8'h00);
        wait_cycles(150);
        rd_reg(3'd5, v); check("R4 May has 31 days", v, 8'h31);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99, 8'h00);
        wait_cycles(150);
        rd_reg(3'd7, v); check("R4 year 99 to 00", v, 8'h00);
        rd_reg(3'd6, v); check("R4 December to January", v, 8'h01);

        // R9 clamping under the load bit
        wr_reg(3'd0, 8'h80);
        wr_reg(3'd1, 8'h7A); rd_reg(3'd1, v); check("R9 sec clamp", v, 8'h59);
        wr_reg(3'd2, 8'h5F); rd_reg(3'd2, v); check("R9 min bad digit", v, 8'h59);
        wr_reg(3'd3, 8'h24); rd_reg(3'd3, v); check("R9 hour clamp", v, 8'h23);
        wr_reg(3'd4, 8'h09); rd_reg(3'd4, v); check("R9 dow clamp", v, 8'h07);
        wr_reg(3'd5, 8'h00); rd_reg(3'd5, v); check("R9 date minimum", v, 8'h01);
        wr_reg(3'd6, 8'h13); rd_reg(3'd6, v); check("R9 month clamp", v, 8'h12);

        // R5 control readback
        wr_reg(3'd0, 8'h25); rd_reg(3'd0, v); check("R5 ctrl readback", v, 8'h25);
        wr_reg(3'd0, 8'h00);

        // R6 freeze with one owed tick
        set_time(8'h10, 8'h00, 8'h12, 8'h02, 8'h15, 8'h06, 8'h30, 8'h00);
        wait_cycles(30);
        wr_reg(3'd0, 8'h40);
        rd_reg(3'd1, v); check("R6 frozen start", v, 8'h10);
        wait_cycles(100);
        rd_reg(3'd1, v); check("R6 frozen across tick", v, 8'h10);
        wr_reg(3'd0, 8'h00);
        rd_reg(3'd1, v); check("R6 owed second applied", v, 8'h11);

        // R10 trim: positive shortens, negative lengthens
        set_time(8'h57, 8'h00, 8'h08, 8'h02, 8'h15, 8'h06, 8'h30, 8'h0A);
        last_second_len(len);
        check("R10 positive trim +10", 8'(len), 8'(DIV - 10 * PST));
        set_time(8'h57, 8'h00, 8'h08, 8'h02, 8'h15, 8'h06, 8'h30, 8'h2A);
        last_second_len(len);
        check("R10 negative trim -10", 8'(len), 8'(DIV + 10 * NST));
        set_time(8'h57, 8'h00, 8'h08, 8'h02, 8'h15, 8'h06, 8'h30, 8'h00);
        last_second_len(len);
        check("R10 zero trim", 8'(len), 8'(DIV));

        wait_cycles(5);
        $display("  test done: total=%0d bad=%0d", n_total + c_total, n_bad + c_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_total + c_total + 1, n_bad + c_bad + 1);
        $finish;
    end
endmodule